// File: doc/BRIEF.md
# Grouped Sigma-Delta Phase-Delay Controller

This block sets when each channel of a multi-channel sigma-delta converter opens its decimation window, so that the phase of one channel can be trimmed against another. One group trigger starts every channel together. Each channel then waits for its own programmable number of modulator clocks before its first window opens. After that, windows of OSR modulator clocks follow back to back. Every modulator clock is one cycle of `clk`.

With an 8-bit wait value and a default of 128, a single trigger can shift a channel either way. Lowering the value makes the channel lead and raising it makes the channel lag. At 256 clocks per sample and a 4096 Hz output rate, one step is 360·fIN/(OSR·fS) degrees. That is roughly 0.02° on a 60 Hz line, so ±128 steps give about ±2.6°. For larger shifts, a per-channel line of 0 to 3 whole-sample stages delays the filtered samples. Each channel captures a sample at the end of every window.

The wait values may be rewritten while conversion runs, for example to follow temperature drift. A new value is adopted at the channel's next window boundary. No window is ever cut short.

Top module: `sd_phase_delay_ctrl`

## Requirements
- R1: After reset, every channel reads preload 128 and sample depth 0. `running`, `win_start`, `win_done`, `smp_out` and `smp_out_vld` are all zero.
- R2: A write with `wr_sel`=0 stores `wr_data` as the preload of channel `wr_ch`. A write with `wr_sel`=1 stores `wr_data[1:0]` as its sample depth. A write to a channel number of NCH or above changes nothing. `rd_data` shows the selected field (the depth zero-extended) in the same cycle, and reads 0 for channel numbers of NCH or above.
- R3: Count the first cycle after the edge that accepts the trigger as cycle 0. A channel with preload P then raises `win_start` in cycle P, P+OSR, P+2·OSR and so on. It raises `win_done` for one cycle in cycles P+OSR-1, P+2·OSR-1 and so on.
- R4: A trigger that arrives while `running` is high is ignored. A trigger and a stop in the same cycle count as a stop.
- R5: A preload rewritten during a run is adopted at the channel's next `win_done` edge. From then on, window starts fall on cycles congruent to the new preload modulo OSR. The first such start is the earliest one after that boundary, so no window is shortened.
- R6: `smp_in` is captured at every `win_done` edge. With depth d, the next cycle carries a one-cycle `smp_out_vld` pulse only once d earlier samples of the run are held. `smp_out` then equals the sample captured d windows earlier. The depth is taken from its register at the trigger, and writes during a run do not change it.
- R7: A stop clears all counters and delay lines. `running`, the strobes and `smp_out_vld` are zero from the next cycle. A later trigger starts the schedule and the filling of the delay line afresh.
- R8: `running` is high from the cycle after an accepted trigger until the cycle after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_start | input | 1 | Group trigger for all channels |
| grp_stop | input | 1 | Stop; clears counters and delay lines |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W | Channel addressed by a write |
| wr_sel | input | 1 | 0 selects the preload, 1 selects the sample depth |
| wr_data | input | PRE_W | Write data |
| rd_ch | input | CH_W | Channel addressed by a read |
| rd_sel | input | 1 | 0 selects the preload, 1 selects the sample depth |
| rd_data | output | PRE_W | Read data |
| smp_in | input | NCH*DW | Filtered sample of each channel; channel c sits at bits c*DW upward |
| running | output | 1 | Conversion active |
| win_start | output | NCH | First clock of a channel's window |
| win_done | output | NCH | Last clock of a channel's window |
| smp_out | output | NCH*DW | Delayed sample of each channel |
| smp_out_vld | output | NCH | One-cycle valid for each channel's `smp_out` |

## Verification
The bench builds the block with three channels, OSR of 16, an 8-bit preload and a 2-bit depth field. A full preload of 255 therefore spans many windows, so the wait counter, the back-to-back window counter and a full delay line can all be exercised in a few hundred cycles per run. This makes a sweep over every preload value in the 8-bit range practical, with each channel also given a different sample depth. Directed runs cover rewrites that lead and that lag during a run, retriggers, stops, and a simultaneous trigger and stop. For every cycle the bench predicts each strobe, valid and sample from modular arithmetic on the cycle index.

// File: rtl/sdpd_pkg.sv
package sdpd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_WIN  = 2'd2
  } tmr_state_e;

  // Clocks to insert after a window boundary so that the next start lands on
  // the new preload modulo the window length.
  function automatic int unsigned gap_calc(input int unsigned new_p,
                                           input int unsigned old_p,
                                           input int unsigned osr);
    int unsigned d;
    if (new_p >= old_p) d = (new_p - old_p) % osr;
    else                d = (osr - ((old_p - new_p) % osr)) % osr;
    return d;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdpd_regs.sv
module sdpd_regs #(
  parameter int NCH     = 3,
  parameter int PRE_W   = 8,
  parameter int DEP_W   = 2,
  parameter int PRE_RST = 128,
  parameter int CH_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [CH_W-1:0]             wr_ch,
  input  logic                        wr_sel,
  input  logic [PRE_W-1:0]            wr_data,
  input  logic [CH_W-1:0]             rd_ch,
  input  logic                        rd_sel,
  output logic [PRE_W-1:0]            rd_data,
  output logic [NCH-1:0][PRE_W-1:0]   pre_q,
  output logic [NCH-1:0][DEP_W-1:0]   dep_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        pre_q[i] <= PRE_W'(PRE_RST);
        dep_q[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (int'(wr_ch) == i) begin
          if (wr_sel) dep_q[i] <= wr_data[DEP_W-1:0];
          else        pre_q[i] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (int'(rd_ch) == i) rd_data = rd_sel ? PRE_W'(dep_q[i]) : pre_q[i];
    end
  end

  // R2: without a write strobe the stored fields never move
  p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pre_q) && $stable(dep_q)));

endmodule

// File: rtl/sdpd_chan_timer.sv
module sdpd_chan_timer
  import sdpd_pkg::*;
#(
  parameter int OSR   = 256,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             halt,
  input  logic [PRE_W-1:0] pre_reg,
  output logic             win_start,
  output logic             win_done,
  output logic             active
);

  localparam int WC_W  = $clog2(OSR);
  localparam int CW    = int'(max2(PRE_W, WC_W));
  localparam int LEN_W = WC_W + 1;

  tmr_state_e       state_q;
  logic [CW-1:0]    cnt_q;
  logic [WC_W-1:0]  wcnt_q;
  logic [PRE_W-1:0] pre_act_q;
  logic [CW-1:0]    gap_w;
  logic             last_clk;

  assign gap_w     = CW'(gap_calc(32'(pre_reg), 32'(pre_act_q), OSR));
  assign last_clk  = (wcnt_q == WC_W'(OSR - 1));
  assign win_start = (state_q == ST_WIN) && (wcnt_q == '0);
  assign win_done  = (state_q == ST_WIN) && last_clk;
  assign active    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n || halt) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      wcnt_q    <= '0;
      pre_act_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (trig) begin
            pre_act_q <= pre_reg;
            wcnt_q    <= '0;
            if (pre_reg == '0) state_q <= ST_WIN;
            else begin
              state_q <= ST_PRE;
              cnt_q   <= CW'(pre_reg - 1'b1);
            end
          end
        end
        ST_PRE: begin
          if (cnt_q == '0) begin
            state_q <= ST_WIN;
            wcnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WIN: begin
          if (last_clk) begin
            pre_act_q <= pre_reg;
            wcnt_q    <= '0;
            if (gap_w != '0) begin
              state_q <= ST_PRE;
              cnt_q   <= gap_w - 1'b1;
            end
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Independent window-length tracker for the assertions below
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk) begin
    if (!rst_n || halt)         len_q <= '0;
    else if (win_start)         len_q <= LEN_W'(1);
    else if (state_q == ST_WIN) len_q <= len_q + 1'b1;
  end

  // R3, R5: every window is exactly OSR clocks long, never shortened
  p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> (len_q == LEN_W'(OSR - 1)));

  // R3: the end-of-window strobe is one clock wide
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done);

  // R7: a stop silences both strobes from the next clock
  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!win_start && !win_done && !active));

endmodule

// File: rtl/sdpd_sample_line.sv
module sdpd_sample_line #(
  parameter int DW    = 16,
  parameter int DEP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             halt,
  input  logic [DEP_W-1:0] depth_reg,
  input  logic             capture,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dvld
);

  localparam int MAXD = (1 << DEP_W) - 1;

  logic [DW-1:0]    line_q [MAXD];
  logic [DEP_W-1:0] depth_act_q;
  logic [DEP_W-1:0] fill_q;
  logic [DW-1:0]    tap;

  always_comb begin
    tap = din;
    for (int i = 1; i <= MAXD; i++) begin
      if (int'(depth_act_q) == i) tap = line_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || halt) begin
      for (int i = 0; i < MAXD; i++) line_q[i] <= '0;
      fill_q <= '0;
      dout   <= '0;
      dvld   <= 1'b0;
      if (!rst_n) depth_act_q <= '0;
    end else begin
      dvld <= 1'b0;
      if (trig) depth_act_q <= depth_reg;
      if (capture) begin
        line_q[0] <= din;
        for (int i = 1; i < MAXD; i++) line_q[i] <= line_q[i-1];
        if (fill_q != DEP_W'(MAXD)) fill_q <= fill_q + 1'b1;
        if (fill_q >= depth_act_q) begin
          dout <= tap;
          dvld <= 1'b1;
        end
      end
    end
  end

  // R6: a valid pulse only follows a capture edge
  p_valid_after_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dvld |-> $past(capture));

  // R6: valid is a single-cycle pulse since windows are longer than one clock
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dvld |=> !dvld);

endmodule

// File: rtl/sd_phase_delay_ctrl.sv
module sd_phase_delay_ctrl #(
  parameter int NCH     = 3,
  parameter int OSR     = 256,
  parameter int PRE_W   = 8,
  parameter int DEP_W   = 2,
  parameter int DW      = 16,
  parameter int PRE_RST = 128,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_start,
  input  logic              grp_stop,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic              wr_sel,
  input  logic [PRE_W-1:0]  wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              rd_sel,
  output logic [PRE_W-1:0]  rd_data,
  input  logic [NCH*DW-1:0] smp_in,
  output logic              running,
  output logic [NCH-1:0]    win_start,
  output logic [NCH-1:0]    win_done,
  output logic [NCH*DW-1:0] smp_out,
  output logic [NCH-1:0]    smp_out_vld
);

  logic [NCH-1:0][PRE_W-1:0] pre_q;
  logic [NCH-1:0][DEP_W-1:0] dep_q;
  logic [NCH-1:0]            chan_active;
  logic                      running_q;
  logic                      trig_ok;

  assign trig_ok = grp_start && !grp_stop && !running_q;
  assign running = running_q;

  always_ff @(posedge clk) begin
    if (!rst_n || grp_stop) running_q <= 1'b0;
    else if (trig_ok)       running_q <= 1'b1;
  end

  sdpd_regs #(
    .NCH(NCH), .PRE_W(PRE_W), .DEP_W(DEP_W), .PRE_RST(PRE_RST), .CH_W(CH_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
    .pre_q(pre_q), .dep_q(dep_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    sdpd_chan_timer #(.OSR(OSR), .PRE_W(PRE_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .trig(trig_ok), .halt(grp_stop),
      .pre_reg(pre_q[c]),
      .win_start(win_start[c]), .win_done(win_done[c]),
      .active(chan_active[c])
    );

    sdpd_sample_line #(.DW(DW), .DEP_W(DEP_W)) i_line (
      .clk(clk), .rst_n(rst_n), .trig(trig_ok), .halt(grp_stop),
      .depth_reg(dep_q[c]), .capture(win_done[c]),
      .din(smp_in[c*DW +: DW]),
      .dout(smp_out[c*DW +: DW]), .dvld(smp_out_vld[c])
    );
  end

  // R4: an accepted trigger only ever meets idle channel timers
  p_trig_only_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |-> (chan_active == '0));

  // R7: a stop empties every channel by the next clock
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grp_stop |=> (!running_q && chan_active == '0 && smp_out_vld == '0));

  // R8: running channels imply the running flag
  p_active_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_active != '0) |-> running_q);

endmodule

// File: tb/test_sd_phase_delay_ctrl.sv
module test_sd_phase_delay_ctrl;

  localparam int NCH = 3, OSR = 16, PRE_W = 8, DEP_W = 2, DW = 16;
  localparam int CH_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic grp_start = 0, grp_stop = 0, wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [CH_W-1:0] wr_ch = '0, rd_ch = '0;
  logic [PRE_W-1:0] wr_data = '0, rd_data;
  logic [NCH*DW-1:0] smp_in = '0, smp_out;
  logic running;
  logic [NCH-1:0] win_start, win_done, smp_out_vld;

  sd_phase_delay_ctrl #(.NCH(NCH), .OSR(OSR), .PRE_W(PRE_W), .DEP_W(DEP_W), .DW(DW))
  i_sd_phase_delay_ctrl (
    .clk(clk), .rst_n(rst_n), .grp_start(grp_start), .grp_stop(grp_stop),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data), .smp_in(smp_in),
    .running(running), .win_start(win_start), .win_done(win_done),
    .smp_out(smp_out), .smp_out_vld(smp_out_vld)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, run_id = 0;
  bit done = 0;
  int cur_p [NCH];
  int cur_d [NCH];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int val(int c, int t, int r);
    return (c << 14) | ((r & 3) << 12) | (t & 12'hfff);
  endfunction

  function automatic bit e_ws(int p, int t);
    return (t >= p) && (((t - p) % OSR) == 0);
  endfunction

  function automatic bit e_wd(int p, int t);
    return (t >= p) && (((t - p) % OSR) == OSR - 1);
  endfunction

  task automatic wr(input int ch, input bit sel, input int data);
    @(negedge clk);
    wr_en = 1; wr_ch = CH_W'(ch); wr_sel = sel; wr_data = PRE_W'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input int ch, input bit sel, input int exp);
    rd_ch = CH_W'(ch); rd_sel = sel; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic load_cfg();
    for (int c = 0; c < NCH; c++) begin
      wr(c, 0, cur_p[c]);
      wr(c, 1, cur_d[c]);
    end
  endtask

  task automatic do_stop();
    @(negedge clk);
    grp_start = 0; wr_en = 0; grp_stop = 1;
    @(negedge clk);
    grp_stop = 0;
    chk("R7 running after stop", running, 0);
    chk("R7 win_start after stop", win_start, 0);
    chk("R7 win_done after stop", win_done, 0);
    chk("R7 vld after stop", smp_out_vld, 0);
  endtask

  // One run with per-cycle prediction of every strobe, valid and sample
  task automatic run_case(input int tlen, input bit disturb, input string vtag);
    run_id++;
    @(negedge clk);
    grp_start = 1;
    @(posedge clk);
    for (int t = 0; t < tlen; t++) begin
      @(negedge clk);
      grp_start = 0; wr_en = 0;
      if (disturb && t == 30) begin
        wr_en = 1; wr_ch = 0; wr_sel = 1; wr_data = PRE_W'((cur_d[0] + 1) % 4);
      end
      if (disturb && t == 32) grp_start = 1;
      for (int c = 0; c < NCH; c++) smp_in[c*DW +: DW] = DW'(val(c, t, run_id));
      chk($sformatf("R8 running t=%0d", t), running, 1);
      for (int c = 0; c < NCH; c++) begin
        int p = cur_p[c], d = cur_d[c];
        bit ev = 0;
        int w = 0;
        chk($sformatf("R3 win_start ch%0d p=%0d t=%0d", c, p, t), win_start[c], e_ws(p, t));
        chk($sformatf("R3 win_done ch%0d p=%0d t=%0d", c, p, t), win_done[c], e_wd(p, t));
        if (t >= 1 && e_wd(p, t - 1)) begin
          w = (t - 1 - p) / OSR;
          ev = (w >= d);
        end
        chk($sformatf("%s vld ch%0d d=%0d t=%0d", vtag, c, d, t), smp_out_vld[c], ev);
        if (ev)
          chk($sformatf("%s data ch%0d d=%0d t=%0d", vtag, c, d, t),
              smp_out[c*DW +: DW], val(c, p + (w - d + 1) * OSR - 1, run_id) & 16'hffff);
      end
    end
    do_stop();
  endtask

  // Expected starts when a channel's preload moves from 5 to pn before cycle 20
  function automatic bit m_ws(int pn, int t);
    int first;
    if (t < 0) return 0;
    if (t <= 20) return e_ws(5, t);
    first = 21 + (((pn - 21) % OSR) + OSR) % OSR;
    return (t >= first) && (((t - first) % OSR) == 0);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset values
    for (int c = 0; c < NCH; c++) begin
      rd_chk($sformatf("R1 preload ch%0d", c), c, 0, 128);
      rd_chk($sformatf("R1 depth ch%0d", c), c, 1, 0);
    end
    chk("R1 running", running, 0);
    chk("R1 win_start", win_start, 0);
    chk("R1 win_done", win_done, 0);
    chk("R1 smp_out", smp_out, 0);
    chk("R1 vld", smp_out_vld, 0);

    // R2: writes, masking of the depth field, out-of-range channel
    wr(1, 0, 200);
    wr(2, 1, 7);
    wr(3, 0, 77);
    wr(3, 1, 1);
    @(negedge clk);
    rd_chk("R2 preload ch1", 1, 0, 200);
    rd_chk("R2 depth ch2 masked", 2, 1, 3);
    rd_chk("R2 preload ch0 untouched", 0, 0, 128);
    rd_chk("R2 preload ch2 untouched", 2, 0, 128);
    rd_chk("R2 depth ch0 untouched", 0, 1, 0);
    rd_chk("R2 channel 3 reads zero", 3, 0, 0);

    // R3, R6, R8: sweep of every preload value with varied depths
    for (int k = 0; k < 86; k++) begin
      int mx = 0;
      for (int c = 0; c < NCH; c++) begin
        cur_p[c] = (3 * k + c) % 256;
        cur_d[c] = (k + c) % 4;
        if (cur_p[c] > mx) mx = cur_p[c];
      end
      load_cfg();
      run_case(mx + 6 * OSR, 0, "R6");
    end

    // R4, R6: retrigger during a run and depth write during a run
    cur_p[0] = 4; cur_p[1] = 0; cur_p[2] = 9;
    cur_d[0] = 1; cur_d[1] = 2; cur_d[2] = 0;
    load_cfg();
    run_case(120, 1, "R4 R6");
    rd_chk("R6 depth register took mid-run write", 0, 1, 2);

    // R4: stop together with a trigger
    @(negedge clk);
    grp_start = 1; grp_stop = 1;
    @(negedge clk);
    grp_start = 0; grp_stop = 0;
    for (int t = 0; t < 5; t++) begin
      chk($sformatf("R4 stop wins running t=%0d", t), running, 0);
      chk($sformatf("R4 stop wins win_start t=%0d", t), win_start, 0);
      @(negedge clk);
    end

    // R5: preload rewrites during a run, one lag and one lead
    for (int c = 0; c < NCH; c++) begin cur_p[c] = 5; cur_d[c] = 0; end
    load_cfg();
    @(negedge clk);
    grp_start = 1;
    @(posedge clk);
    for (int t = 0; t < 100; t++) begin
      int pn [NCH];
      pn[0] = 9; pn[1] = 2; pn[2] = 5;
      @(negedge clk);
      grp_start = 0; wr_en = 0;
      if (t == 10) begin wr_en = 1; wr_ch = 0; wr_sel = 0; wr_data = 9; end
      if (t == 11) begin wr_en = 1; wr_ch = 1; wr_sel = 0; wr_data = 2; end
      for (int c = 0; c < NCH; c++) begin
        chk($sformatf("R5 win_start ch%0d t=%0d", c, t), win_start[c], m_ws(pn[c], t));
        chk($sformatf("R5 win_done ch%0d t=%0d", c, t), win_done[c], m_ws(pn[c], t - OSR + 1));
      end
    end
    do_stop();

    // R7: two runs in a row; the second must refill its delay line from empty
    for (int c = 0; c < NCH; c++) begin cur_p[c] = 3 + c; cur_d[c] = 2 + (c % 2); end
    load_cfg();
    run_case(100, 0, "R7");
    run_case(100, 0, "R7");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule